// File: doc/BRIEF.md
# Pipelined Fixed-Point Interval Arithmetic Unit

This unit computes on closed intervals. Each operand is a pair of signed Q1.15 numbers, a lower bound and an upper bound. Two bound lanes run side by side, and each one forms its own bound of the result. One lane takes the minimum side and the other takes the maximum side. The unit supports these operations:

- interval sum and difference;
- interval product;
- hull (set union) and meet (set intersection);
- an interval multiply-accumulate for dot products;
- division by a power of two, done as an arithmetic right shift of both bounds.

A new operation can be issued every clock cycle. Each result comes out exactly three cycles after it was issued. The result carries a valid flag, and an empty flag for an intersection that has no members.

Callers must supply operands with lower bound not above upper bound. A dot product is begun with the clear operation, followed by one accumulate operation per element pair. Each accumulate returns the running sum, converted back to Q1.15 with saturation.

Top module: `ival_alu`

## Requirements
- R1: A result appears exactly 3 clock cycles after the operation is sampled. `out_valid` is `in_valid` delayed by those 3 cycles. An operation may be issued every cycle, and a cycle with `in_valid` low yields a cycle with `out_valid` low.
- R2: Opcode 0 (sum) returns [a_lo+b_lo, a_hi+b_hi]. Each bound is clamped to [-32768, 32767].
- R3: Opcode 1 (difference) returns [a_lo-b_hi, a_hi-b_lo]. Each bound is clamped to [-32768, 32767].
- R4: Opcode 2 (product) forms the four 32-bit cross products of the bounds. The lower result is the smallest product and the upper result is the largest. Each is arithmetically shifted right by 15 (rounded toward minus infinity) and clamped, so [-32768,-32768]·[-32768,-32768] gives [32767, 32767].
- R5: Opcode 3 (hull) returns [min(a_lo,b_lo), max(a_hi,b_hi)] with `out_empty` low.
- R6: Opcode 4 (meet) returns [max(a_lo,b_lo), min(a_hi,b_hi)]. `out_empty` is high exactly when that lower bound exceeds that upper bound, and is low for every other opcode.
- R7: Opcode 5 (accumulate) adds the smallest cross product to a 40-bit lower accumulator and the largest cross product to a 40-bit upper accumulator. Each accumulator saturates at the 40-bit signed range. The returned bounds are the updated accumulators shifted right by 15 and clamped to 16 bits. Back-to-back accumulates in consecutive cycles all take effect.
- R8: Opcode 6 (clear) sets both accumulators to 0 and returns [0, 0].
- R9: Opcode 7 (shift) returns [a_lo >>> s, a_hi >>> s] with s = `in_shamt` (0..15). The b operand is not used.
- R10: While reset is high, `out_valid` and `out_empty` are low. After reset both accumulators read 0.
- R11: Opcodes other than 5 and 6, and any cycle with `in_valid` low, leave both accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode (encodings in R2 to R9) |
| in_a_lo | input | 16 | Operand a lower bound, signed Q1.15 |
| in_a_hi | input | 16 | Operand a upper bound, signed Q1.15 |
| in_b_lo | input | 16 | Operand b lower bound, signed Q1.15 |
| in_b_hi | input | 16 | Operand b upper bound, signed Q1.15 |
| in_shamt | input | 4 | Right-shift amount for opcode 7 |
| out_valid | output | 1 | Result strobe |
| out_lo | output | 16 | Result lower bound, signed Q1.15 |
| out_hi | output | 16 | Result upper bound, signed Q1.15 |
| out_empty | output | 1 | Meet result has no members |

## Verification
The only hidden state is the pair of accumulators and the pipeline registers. A wrong accumulator value is invisible until the next accumulate, which then returns a wrong bound on its own result three cycles after issue. A dropped or doubled pipeline stage shows at once, as a valid or result strobe one cycle off. A swapped minimum/maximum selection, a wrong clamp or a misplaced shift shows on the very result of the faulty operation. The stimulus therefore interleaves non-accumulating operations and idle cycles between accumulates, and it uses extreme bound values to reach the clamps.

// File: rtl/ival_pkg.sv
package ival_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MUL  = 3'd2,
      OP_HULL = 3'd3,
      OP_MEET = 3'd4,
      OP_MAC  = 3'd5,
      OP_MCLR = 3'd6,
      OP_SHR  = 3'd7
   } ival_op_e;

endpackage

// File: rtl/ival_cross_prod.sv
module ival_cross_prod #(
   parameter int W = 16,
   localparam int PW = 2 * W
) (
   input  logic signed [W-1:0]  a_lo,
   input  logic signed [W-1:0]  a_hi,
   input  logic signed [W-1:0]  b_lo,
   input  logic signed [W-1:0]  b_hi,
   output logic signed [PW-1:0] prod [4]
);

   logic signed [PW-1:0] aw [2];
   logic signed [PW-1:0] bw [2];

   assign aw[0] = {{W{a_lo[W-1]}}, a_lo};
   assign aw[1] = {{W{a_hi[W-1]}}, a_hi};
   assign bw[0] = {{W{b_lo[W-1]}}, b_lo};
   assign bw[1] = {{W{b_hi[W-1]}}, b_hi};

   // index k: bit 1 picks the a bound, bit 0 the b bound
   for (genvar k = 0; k < 4; k++) begin : g_xp
      assign prod[k] = aw[k / 2] * bw[k % 2];
   end

endmodule

// File: rtl/ival_bound_lane.sv
module ival_bound_lane import ival_pkg::*; #(
   parameter int W     = 16,
   parameter int FRAC  = 15,
   parameter int ACCW  = 40,
   parameter bit UPPER = 1'b0,
   localparam int SW   = $clog2(W),
   localparam int PW   = 2 * W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   v_in,
   input  ival_op_e               op,
   input  logic signed [W-1:0]    own_a,
   input  logic signed [W-1:0]    own_b,
   input  logic signed [W-1:0]    cross_b,
   input  logic [SW-1:0]          sh,
   input  logic signed [PW-1:0]   prod [4],
   output logic signed [ACCW-1:0] wide_q,
   output logic signed [W-1:0]    res_q
);

   if (ACCW < PW + 1) begin : g_bad_accw
      $error("ival_bound_lane: ACCW must exceed the product width");
   end
   if (FRAC >= W || FRAC + W + 1 > ACCW) begin : g_bad_frac
      $error("ival_bound_lane: FRAC out of range");
   end

   localparam logic signed [ACCW-1:0] ACC_MAX = {1'b0, {(ACCW-1){1'b1}}};
   localparam logic signed [ACCW-1:0] ACC_MIN = {1'b1, {(ACCW-1){1'b0}}};
   localparam logic signed [W-1:0]    OUT_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0]    OUT_MIN = {1'b1, {(W-1){1'b0}}};

   function automatic logic signed [ACCW-1:0] grow_b(input logic signed [W:0] v);
      return {{(ACCW-W-1){v[W]}}, v};
   endfunction

   logic signed [ACCW-1:0] prod_w [4];
   logic signed [ACCW-1:0] sel;
   logic signed [W-1:0]    hull_v;
   logic signed [W-1:0]    meet_v;

   for (genvar k = 0; k < 4; k++) begin : g_pw
      assign prod_w[k] = {{(ACCW-PW){prod[k][PW-1]}}, prod[k]};
   end

   // variant: upper lane keeps the largest values, lower lane the smallest
   if (UPPER) begin : g_up
      always_comb begin
         sel = prod_w[0];
         for (int k = 1; k < 4; k++) begin
            if (prod_w[k] > sel) sel = prod_w[k];
         end
         hull_v = (own_a > own_b) ? own_a : own_b;
         meet_v = (own_a < own_b) ? own_a : own_b;
      end
   end else begin : g_dn
      always_comb begin
         sel = prod_w[0];
         for (int k = 1; k < 4; k++) begin
            if (prod_w[k] < sel) sel = prod_w[k];
         end
         hull_v = (own_a < own_b) ? own_a : own_b;
         meet_v = (own_a > own_b) ? own_a : own_b;
      end
   end

   logic signed [ACCW-1:0] acc_q;
   logic signed [ACCW:0]   acc_sum;
   logic signed [ACCW-1:0] acc_nx;
   logic signed [W:0]      sum_v;
   logic signed [W:0]      dif_v;
   logic signed [W-1:0]    shr_v;
   logic signed [ACCW-1:0] wide_d;

   always_comb begin
      acc_sum = {acc_q[ACCW-1], acc_q} + {sel[ACCW-1], sel};
      if (acc_sum[ACCW] != acc_sum[ACCW-1]) begin
         acc_nx = acc_sum[ACCW] ? ACC_MIN : ACC_MAX;
      end else begin
         acc_nx = acc_sum[ACCW-1:0];
      end
      sum_v = {own_a[W-1], own_a} + {own_b[W-1], own_b};
      dif_v = {own_a[W-1], own_a} - {cross_b[W-1], cross_b};
      shr_v = own_a >>> sh;
      case (op)
         OP_ADD:  wide_d = grow_b(sum_v) <<< FRAC;
         OP_SUB:  wide_d = grow_b(dif_v) <<< FRAC;
         OP_MUL:  wide_d = sel;
         OP_HULL: wide_d = grow_b({hull_v[W-1], hull_v}) <<< FRAC;
         OP_MEET: wide_d = grow_b({meet_v[W-1], meet_v}) <<< FRAC;
         OP_MAC:  wide_d = acc_nx;
         OP_MCLR: wide_d = '0;
         OP_SHR:  wide_d = grow_b({shr_v[W-1], shr_v}) <<< FRAC;
         default: wide_d = '0;
      endcase
   end

   // final stage: back to output scale with clamping
   logic signed [ACCW-1:0] shf;
   logic [ACCW-W:0]        top_bits;
   logic signed [W-1:0]    res_d;

   always_comb begin
      shf      = wide_q >>> FRAC;
      top_bits = shf[ACCW-1:W-1];
      if ((&top_bits) || !(|top_bits)) begin
         res_d = shf[W-1:0];
      end else begin
         res_d = shf[ACCW-1] ? OUT_MIN : OUT_MAX;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         wide_q <= '0;
         res_q  <= '0;
      end else begin
         wide_q <= wide_d;
         res_q  <= res_d;
         if (v_in && op == OP_MAC) begin
            acc_q <= acc_nx;
         end else if (v_in && op == OP_MCLR) begin
            acc_q <= '0;
         end
      end
   end

   // R11: accumulator holds unless an accumulate or clear is issued
   assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !(v_in && (op == OP_MAC || op == OP_MCLR)) |=> $stable(acc_q));

   // R8: clear zeroes the accumulator and the returned bound
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (v_in && op == OP_MCLR) |=> (acc_q == '0 && wide_q == '0));

   // R4: the selected product bounds all four cross products
   if (UPPER) begin : g_chk_up
      assert_pick_max_R4: assert property (@(posedge clk) disable iff (rst)
         (v_in && op == OP_MUL) |=>
            (wide_q >= $past(prod_w[0]) && wide_q >= $past(prod_w[1]) &&
             wide_q >= $past(prod_w[2]) && wide_q >= $past(prod_w[3])));
   end else begin : g_chk_dn
      assert_pick_min_R4: assert property (@(posedge clk) disable iff (rst)
         (v_in && op == OP_MUL) |=>
            (wide_q <= $past(prod_w[0]) && wide_q <= $past(prod_w[1]) &&
             wide_q <= $past(prod_w[2]) && wide_q <= $past(prod_w[3])));
   end

endmodule

// File: rtl/ival_alu.sv
module ival_alu import ival_pkg::*; #(
   parameter int W    = 16,
   parameter int FRAC = 15,
   parameter int ACCW = 40,
   localparam int SW  = $clog2(W),
   localparam int PW  = 2 * W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [2:0]          in_op,
   input  logic signed [W-1:0] in_a_lo,
   input  logic signed [W-1:0] in_a_hi,
   input  logic signed [W-1:0] in_b_lo,
   input  logic signed [W-1:0] in_b_hi,
   input  logic [SW-1:0]       in_shamt,
   output logic                out_valid,
   output logic signed [W-1:0] out_lo,
   output logic signed [W-1:0] out_hi,
   output logic                out_empty
);

   if (W < 2 || (1 << SW) != W) begin : g_bad_w
      $error("ival_alu: W must be a power of two of at least 2");
   end

   logic signed [PW-1:0] prod_c [4];

   ival_cross_prod #(.W(W)) u_xp (
      .a_lo (in_a_lo),
      .a_hi (in_a_hi),
      .b_lo (in_b_lo),
      .b_hi (in_b_hi),
      .prod (prod_c)
   );

   // stage A: operands and cross products
   logic                 va;
   ival_op_e             op_a;
   logic signed [W-1:0]  alo_a, ahi_a, blo_a, bhi_a;
   logic [SW-1:0]        sh_a;
   logic signed [PW-1:0] prod_a [4];

   always_ff @(posedge clk) begin
      if (rst) begin
         va    <= 1'b0;
         op_a  <= OP_ADD;
         alo_a <= '0;
         ahi_a <= '0;
         blo_a <= '0;
         bhi_a <= '0;
         sh_a  <= '0;
         for (int k = 0; k < 4; k++) prod_a[k] <= '0;
      end else begin
         va    <= in_valid;
         op_a  <= ival_op_e'(in_op);
         alo_a <= in_a_lo;
         ahi_a <= in_a_hi;
         blo_a <= in_b_lo;
         bhi_a <= in_b_hi;
         sh_a  <= in_shamt;
         for (int k = 0; k < 4; k++) prod_a[k] <= prod_c[k];
      end
   end

   logic signed [ACCW-1:0] lo_wide, hi_wide;
   logic signed [W-1:0]    lo_res, hi_res;

   ival_bound_lane #(.W(W), .FRAC(FRAC), .ACCW(ACCW), .UPPER(1'b0)) u_lo (
      .clk     (clk),
      .rst     (rst),
      .v_in    (va),
      .op      (op_a),
      .own_a   (alo_a),
      .own_b   (blo_a),
      .cross_b (bhi_a),
      .sh      (sh_a),
      .prod    (prod_a),
      .wide_q  (lo_wide),
      .res_q   (lo_res)
   );

   ival_bound_lane #(.W(W), .FRAC(FRAC), .ACCW(ACCW), .UPPER(1'b1)) u_hi (
      .clk     (clk),
      .rst     (rst),
      .v_in    (va),
      .op      (op_a),
      .own_a   (ahi_a),
      .own_b   (bhi_a),
      .cross_b (blo_a),
      .sh      (sh_a),
      .prod    (prod_a),
      .wide_q  (hi_wide),
      .res_q   (hi_res)
   );

   // stages B and C: control alongside the lanes
   logic vb, meet_b, vc, empty_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         vb      <= 1'b0;
         meet_b  <= 1'b0;
         vc      <= 1'b0;
         empty_c <= 1'b0;
      end else begin
         vb      <= va;
         meet_b  <= va && (op_a == OP_MEET);
         vc      <= vb;
         empty_c <= vb && meet_b && (lo_wide > hi_wide);
      end
   end

   assign out_valid = vc;
   assign out_empty = empty_c;
   assign out_lo    = lo_res;
   assign out_hi    = hi_res;

   // R1: every result strobe traces back to an issue three cycles earlier
   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid, 3));

   // R6: an empty result is valid and has crossed bounds
   assert_empty_order_R6: assert property (@(posedge clk) disable iff (rst)
      out_empty |-> (out_valid && out_lo > out_hi));

endmodule

// File: tb/ival_alu_tb_top.sv
`timescale 1ns/1ps
module ival_alu_tb_top;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic [2:0]         in_op = 3'd0;
   logic signed [15:0] in_a_lo = '0, in_a_hi = '0, in_b_lo = '0, in_b_hi = '0;
   logic [3:0]         in_shamt = '0;
   logic               out_valid;
   logic signed [15:0] out_lo, out_hi;
   logic               out_empty;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ival_alu dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_a_lo(in_a_lo), .in_a_hi(in_a_hi), .in_b_lo(in_b_lo), .in_b_hi(in_b_hi),
      .in_shamt(in_shamt), .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
      .out_empty(out_empty)
   );

   longint macl = 0, mach = 0;
   bit     pv [3];
   longint plo [3], phi [3];
   bit     pe [3];
   string  ptag [3];

   function automatic longint s16(longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint s40(longint v);
      longint lim = longint'(1) <<< 39;
      if (v > lim - 1) return lim - 1;
      if (v < -lim) return -lim;
      return v;
   endfunction

   function automatic longint mn2(longint a, longint b); return (a < b) ? a : b; endfunction
   function automatic longint mx2(longint a, longint b); return (a > b) ? a : b; endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic compare_out();
      checks++;
      if (pv[2]) begin
         if (!(out_valid === 1'b1 && longint'(out_lo) == plo[2] &&
               longint'(out_hi) == phi[2] && out_empty === pe[2])) begin
            errors++;
            $display("FAIL %s: got v=%0b [%0d,%0d] e=%0b, expected v=1 [%0d,%0d] e=%0b",
                     ptag[2], out_valid, out_lo, out_hi, out_empty, plo[2], phi[2], pe[2]);
         end
      end else begin
         if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got out_valid=%0b, expected 0", out_valid);
         end
      end
   endtask

   task automatic step(input bit v, input int op, input longint alo, input longint ahi,
                       input longint blo, input longint bhi, input int sh, input string tag);
      longint p [4];
      longint pmin, pmax, elo, ehi;
      bit     eemp;
      @(negedge clk);
      compare_out();
      for (int k = 2; k > 0; k--) begin
         pv[k] = pv[k-1]; plo[k] = plo[k-1]; phi[k] = phi[k-1];
         pe[k] = pe[k-1]; ptag[k] = ptag[k-1];
      end
      p[0] = alo * blo; p[1] = alo * bhi; p[2] = ahi * blo; p[3] = ahi * bhi;
      pmin = mn2(mn2(p[0], p[1]), mn2(p[2], p[3]));
      pmax = mx2(mx2(p[0], p[1]), mx2(p[2], p[3]));
      elo = 0; ehi = 0; eemp = 1'b0;
      if (v) begin
         case (op)
            0: begin elo = s16(alo + blo); ehi = s16(ahi + bhi); end
            1: begin elo = s16(alo - bhi); ehi = s16(ahi - blo); end
            2: begin elo = s16(pmin >>> 15); ehi = s16(pmax >>> 15); end
            3: begin elo = mn2(alo, blo); ehi = mx2(ahi, bhi); end
            4: begin elo = mx2(alo, blo); ehi = mn2(ahi, bhi); eemp = (elo > ehi); end
            5: begin
               macl = s40(macl + pmin); mach = s40(mach + pmax);
               elo = s16(macl >>> 15); ehi = s16(mach >>> 15);
            end
            6: begin macl = 0; mach = 0; end
            default: begin elo = alo >>> sh; ehi = ahi >>> sh; end
         endcase
      end
      pv[0] = v; plo[0] = elo; phi[0] = ehi; pe[0] = eemp; ptag[0] = tag;
      in_valid = v; in_op = 3'(op); in_shamt = 4'(sh);
      in_a_lo = 16'(alo); in_a_hi = 16'(ahi); in_b_lo = 16'(blo); in_b_hi = 16'(bhi);
   endtask

   function automatic longint rnd_val();
      case ($urandom % 6)
         0: return -32768;
         1: return 32767;
         2: return 0;
         default: return longint'($signed(16'($urandom)));
      endcase
   endfunction

   string op_tag [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9"};

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20061));
      for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; plo[k] = 0; phi[k] = 0; pe[k] = 1'b0; ptag[k] = "R1"; end
      repeat (3) @(negedge clk);
      // R10: outputs idle under reset, even with a strobe present
      in_valid = 1'b1; in_op = 3'd4; in_a_lo = 16'sd5; in_a_hi = 16'sd6;
      in_b_lo = -16'sd9; in_b_hi = -16'sd8;
      repeat (2) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_empty !== 1'b0) begin
         errors++;
         $display("FAIL R10: got v=%0b e=%0b, expected v=0 e=0", out_valid, out_empty);
      end
      in_valid = 1'b0;
      rst = 1'b0;

      // R10: accumulator starts at zero: 0.5*0.5 gives 0.25 = 8192
      step(1, 5, 16384, 16384, 16384, 16384, 0, "R10");
      step(1, 5, 16384, 16384, 16384, 16384, 0, "R7");
      step(1, 0, 100, 200, 3, 4, 0, "R2");
      // R11: neutral accumulate shows accumulator untouched by the sum and the idle cycle
      step(0, 5, 0, 0, 0, 0, 0, "R1");
      step(1, 5, 0, 0, 0, 0, 0, "R11");
      step(1, 0, 32767, 32767, 1, 1, 0, "R2");
      step(1, 0, -32768, -32768, -1, -1, 0, "R2");
      step(1, 1, 1, 3, 2, 5, 0, "R3");
      step(1, 1, -32768, 0, 1, 32767, 0, "R3");
      step(1, 2, -32768, -32768, -32768, -32768, 0, "R4");
      step(1, 2, -16384, 8192, -8192, 16384, 0, "R4");
      step(1, 3, -5, 10, 3, 20, 0, "R5");
      step(1, 4, 0, 10, 20, 30, 0, "R6");
      step(1, 4, 0, 10, 5, 30, 0, "R6");
      step(1, 6, 7, 8, 9, 10, 0, "R8");
      step(1, 5, -32768, 32767, -32768, 32767, 0, "R7");
      step(1, 6, 0, 0, 0, 0, 0, "R8");
      for (int k = 0; k < 3; k++) step(1, 5, -32768, -32768, -32768, -32768, 0, "R7");
      step(1, 7, -32768, 32767, 0, 0, 15, "R9");
      step(1, 7, -1234, 4321, 0, 0, 0, "R9");
      step(1, 7, -1234, 4321, 0, 0, 3, "R9");

      for (int i = 0; i < 2500; i++) begin
         longint a0 = rnd_val(), a1 = rnd_val(), b0 = rnd_val(), b1 = rnd_val();
         bit     vv = ($urandom % 8) != 0;
         int     op = int'($urandom % 8);
         if (a0 > a1) begin longint t = a0; a0 = a1; a1 = t; end
         if (b0 > b1) begin longint t = b0; b0 = b1; b1 = t; end
         step(vv, op, a0, a1, b0, b1, int'($urandom % 16), vv ? op_tag[op] : "R1");
      end
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, "R1");
      @(negedge clk);
      compare_out();
      summary();
      $finish;
   end

endmodule